// File: doc/BRIEF.md
# Four-Leg Sequential PWM Gate Generator

This block produces the gate timing for a constant-frequency converter with four primary switches, called legs 1 to 4, that share one transformer. It also drives two secondary rectifier switches. A free-running counter acts as a digital sawtooth and sets the switching period; with the default settings that is 100 kHz from a 200 MHz clock. Within each period the legs conduct one after another in the fixed order 1, 2, 3, 4. Legs 1 to 3 take their on-time from three duty command words. Leg 4 fills whatever remains of the period.

The transition into leg 1 and the transition out of it are separated by a programmable dead interval, during which all primary legs are off. At the hand-overs from leg 2 to leg 3 and from leg 3 to leg 4 there is no dead interval. Instead, the incoming leg turns on a programmable overlap before the outgoing leg turns off. The rectifier gates are the inverse of the primary timing, so the secondary always has a conduction path.

Commands are sampled once per period. A set of commands too large to fit the period is trimmed so that leg 4 keeps a minimum on-time. A one-cycle strobe marks each period start so that an external controller can align its sampling. A synchronous enable stops all gates and restarts the sequence cleanly.

Top module: `quad_phase_pwm`

## Requirements
- R1: While enabled, `cycle_mark` is high for exactly one cycle in every PERIOD cycles. Its high cycle is period position 0, the first cycle of the dead interval before leg 1.
- R2: A duty word d (DUTY_W-bit fraction of the period) gives a nominal on-time of floor(d*PERIOD/2^DUTY_W) cycles. Leg 1 is on for exactly that time, `leg_gate[0]`. Leg 2 runs from its start to its nominal end, `leg_gate[1]`. Leg 3 ends at its nominal end, `leg_gate[2]`.
- R3: Legs turn on in the order 1, 2, 3, 4 within a period (`leg_gate` bits 0 to 3). All legs are off for `dead_cyc` cycles at period positions 0 to dead-1. All legs are off again for `dead_cyc` cycles right after leg 1 turns off. No other leg is ever on together with leg 1.
- R4: Leg 3 turns on `ovl_cyc` cycles before leg 2's nominal end. Leg 4 turns on `ovl_cyc` cycles before leg 3's nominal end. Neither starts earlier than the turn-off of the leg two places before it. At most two legs are on at once. Legs 2 and 4 are never on together. A leg whose trimmed on-time is zero stays off.
- R5: Leg 4 stays on from its start until the last cycle of the period.
- R6: Let the budget be PERIOD - 2*dead - MIN_S4 cycles. If the sum of the nominal on-times exceeds it, the on-times are trimmed: leg 3 first, then leg 2, then leg 1. Leg 4 therefore keeps at least MIN_S4 cycles.
- R7: `rect_gate[1]` is low exactly while leg 1 is on. `rect_gate[0]` is low exactly while leg 2 or leg 3 is on. Both are high at every other enabled cycle.
- R8: Duty, dead and overlap inputs are sampled only at the period boundary. A change made during a period has no effect before the next period.
- R9: If `run_en` is sampled low, every gate and `cycle_mark` are low from the next cycle on, whatever the other inputs do. After `run_en` is sampled high again, the first `cycle_mark` appears on the following clock edge.
- R10: While `rst_n` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run_en | input | 1 | Synchronous enable of the gate sequence |
| duty_leg1 | input | DUTY_W | Leg 1 duty fraction |
| duty_leg2 | input | DUTY_W | Leg 2 duty fraction |
| duty_leg3 | input | DUTY_W | Leg 3 duty fraction |
| dead_cyc | input | DT_W | Dead interval in clock cycles |
| ovl_cyc | input | DT_W | Overlap interval in clock cycles |
| leg_gate | output | 4 | Primary gates, bit i = leg i+1 |
| rect_gate | output | 2 | Rectifier gates, bit 0 = mid-leg side, bit 1 = leg 1 side |
| cycle_mark | output | 1 | One-cycle period start strobe |

## Verification
The main function is tried with a nominal command set that has every leg active. Further sets have zero dead and zero overlap, an idle leg 2, an idle leg 3, and an overlap longer than leg 3. These separate the window arithmetic from the gating rule for zero-duty legs. Two over-budget command sets trim leg 3 and then leg 2, and then leg 1 as well. This shows the order of trimming and the minimum leg 4 time. Every new command set is applied at the start of the period before it takes effect, so a design that does not hold its inputs shows up as a mismatch in the running period. A disable and re-enable sequence with inputs toggling while disabled pins down the restart latency.

// File: rtl/qpwm_pkg.sv
package qpwm_pkg;
  localparam int LEGS     = 4;
  localparam int CMD_LEGS = 3;
  localparam int LEG1 = 0;
  localparam int LEG2 = 1;
  localparam int LEG3 = 2;
  localparam int LEG4 = 3;
  localparam int RECT_MID  = 0;
  localparam int RECT_HEAD = 1;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/qpwm_rst_sync.sv
module qpwm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/qpwm_carrier.sv
module qpwm_carrier #(
  parameter int PERIOD = 2000,
  parameter int CNT_W  = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  output logic [CNT_W-1:0] cnt_q,
  output logic             run_q,
  output logic             load
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_d;
  logic             run_d;

  always_comb begin
    load  = run_en && (!run_q || (cnt_q == LAST));
    run_d = run_en;
    if (!run_en || load) cnt_d = '0;
    else                 cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q) && cnt_q != '0) |-> (cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/qpwm_budget.sv
module qpwm_budget
  import qpwm_pkg::*;
#(
  parameter int PERIOD = 2000,
  parameter int DUTY_W = 12,
  parameter int DT_W   = 8,
  parameter int CNT_W  = 11,
  parameter int EW     = 13,
  parameter int MIN_S4 = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               load,
  input  logic [CMD_LEGS-1:0][DUTY_W-1:0]    duty,
  input  logic [DT_W-1:0]                    dead_in,
  input  logic [DT_W-1:0]                    ovl_in,
  output logic [CMD_LEGS-1:0][CNT_W-1:0]     t_q,
  output logic [DT_W-1:0]                    dt_q,
  output logic [DT_W-1:0]                    ov_q
);
  localparam int PW = DUTY_W + CNT_W;
  localparam logic [PW-1:0] PER_P = PW'(PERIOD);
  localparam logic [EW-1:0] PER_E = EW'(PERIOD);
  localparam logic [EW-1:0] MIN_E = EW'(MIN_S4);

  logic [CMD_LEGS-1:0][EW-1:0]    raw;
  logic [CMD_LEGS-1:0][EW-1:0]    clip;
  logic [CMD_LEGS:0][EW-1:0]      room;
  logic [EW-1:0]                  need;
  logic [CMD_LEGS-1:0][CNT_W-1:0] t_d;
  logic [DT_W-1:0]                dt_d;
  logic [DT_W-1:0]                ov_d;

  // duty fraction to cycles, one scaler per commanded leg
  for (genvar g = 0; g < CMD_LEGS; g++) begin : g_scale
    logic [PW-1:0] prod;
    assign prod   = PW'(duty[g]) * PER_P;
    assign raw[g] = EW'(prod >> DUTY_W);
  end

  // leg 1 claims the budget first, leg 3 last
  always_comb begin
    need    = (EW'(dead_in) << 1) + MIN_E;
    room[0] = (need >= PER_E) ? '0 : PER_E - need;
    for (int i = 0; i < CMD_LEGS; i++) begin
      clip[i]   = (raw[i] > room[i]) ? room[i] : raw[i];
      room[i+1] = room[i] - clip[i];
    end
  end

  always_comb begin
    t_d  = t_q;
    dt_d = dt_q;
    ov_d = ov_q;
    if (load) begin
      for (int i = 0; i < CMD_LEGS; i++) t_d[i] = CNT_W'(clip[i]);
      dt_d = dead_in;
      ov_d = ovl_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q  <= '0;
      dt_q <= '0;
      ov_q <= '0;
    end else begin
      t_q  <= t_d;
      dt_q <= dt_d;
      ov_q <= ov_d;
    end
  end

  logic [EW-1:0] need_q;
  logic [EW-1:0] sum_q;
  assign need_q = (EW'(dt_q) << 1) + MIN_E;
  assign sum_q  = EW'(t_q[LEG1]) + EW'(t_q[LEG2]) + EW'(t_q[LEG3]);

  // R6
  budget_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (need_q < PER_E) |-> (sum_q + need_q <= PER_E));

  // R8
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(t_q) && $stable(dt_q) && $stable(ov_q)));
endmodule

// File: rtl/qpwm_decode.sv
module qpwm_decode
  import qpwm_pkg::*;
#(
  parameter int CNT_W = 11,
  parameter int DT_W  = 8,
  parameter int EW    = 13
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           run_en,
  input  logic                           run_q,
  input  logic [CNT_W-1:0]               cnt_q,
  input  logic [CMD_LEGS-1:0][CNT_W-1:0] t_q,
  input  logic [DT_W-1:0]                dt_q,
  input  logic [DT_W-1:0]                ov_q,
  output logic [LEGS-1:0]                leg_q,
  output logic [1:0]                     rect_q,
  output logic                           mark_q
);
  logic [EW-1:0] pos, dt_e, ov_e, e1, a2, b3, b4, s3s, s4s;
  logic [LEGS-1:0][EW-1:0] lo, hi;
  logic [LEGS-1:0] live, on;
  logic            act;
  logic [LEGS-1:0] leg_d;
  logic [1:0]      rect_d;
  logic            mark_d;

  // window edges, all relative to period position 0
  always_comb begin
    pos  = EW'(cnt_q);
    dt_e = EW'(dt_q);
    ov_e = EW'(ov_q);
    e1   = dt_e + EW'(t_q[LEG1]);
    a2   = e1 + dt_e;
    b3   = a2 + EW'(t_q[LEG2]);
    b4   = b3 + EW'(t_q[LEG3]);
    s3s  = (b3 >= a2 + ov_e) ? b3 - ov_e : a2;
    s4s  = (b4 >= b3 + ov_e) ? b4 - ov_e : b3;
    lo[LEG1] = dt_e;  hi[LEG1] = e1;
    lo[LEG2] = a2;    hi[LEG2] = b3;
    lo[LEG3] = s3s;   hi[LEG3] = b4;
    lo[LEG4] = s4s;   hi[LEG4] = '1;
    live       = '1;
    live[LEG3] = (t_q[LEG3] != '0);
  end

  for (genvar g = 0; g < LEGS; g++) begin : g_win
    assign on[g] = live[g] && (pos >= lo[g]) && (pos < hi[g]);
  end

  always_comb begin
    act    = run_en && run_q;
    leg_d  = act ? on : '0;
    rect_d = '0;
    if (act) begin
      rect_d[RECT_HEAD] = ~on[LEG1];
      rect_d[RECT_MID]  = ~(on[LEG2] | on[LEG3]);
    end
    mark_d = act && (cnt_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      leg_q  <= '0;
      rect_q <= '0;
      mark_q <= 1'b0;
    end else begin
      leg_q  <= leg_d;
      rect_q <= rect_d;
      mark_q <= mark_d;
    end
  end

  // R3
  lead_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    leg_q[LEG1] |-> (leg_q[LEG4:LEG2] == '0));

  // R3
  lead_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(leg_q[LEG1]) && dt_q != '0) |-> ($past(leg_q) == '0));

  // R4
  max_two_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(leg_q) <= 2);

  // R4
  mid_tail_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(leg_q[LEG2] && leg_q[LEG4]));
endmodule

// File: rtl/quad_phase_pwm.sv
module quad_phase_pwm
  import qpwm_pkg::*;
#(
  parameter int PERIOD = 2000,
  parameter int DUTY_W = 12,
  parameter int DT_W   = 8,
  parameter int MIN_S4 = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic [DUTY_W-1:0] duty_leg1,
  input  logic [DUTY_W-1:0] duty_leg2,
  input  logic [DUTY_W-1:0] duty_leg3,
  input  logic [DT_W-1:0]   dead_cyc,
  input  logic [DT_W-1:0]   ovl_cyc,
  output logic [3:0]        leg_gate,
  output logic [1:0]        rect_gate,
  output logic              cycle_mark
);
  localparam int CNT_W = $clog2(PERIOD);
  localparam int EW    = max_int(CNT_W, DT_W) + 2;

  logic                           rst_i_n;
  logic [CNT_W-1:0]               cnt_q;
  logic                           run_q;
  logic                           load;
  logic [CMD_LEGS-1:0][DUTY_W-1:0] duty_vec;
  logic [CMD_LEGS-1:0][CNT_W-1:0] t_q;
  logic [DT_W-1:0]                dt_q;
  logic [DT_W-1:0]                ov_q;

  assign duty_vec[LEG1] = duty_leg1;
  assign duty_vec[LEG2] = duty_leg2;
  assign duty_vec[LEG3] = duty_leg3;

  qpwm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  qpwm_carrier #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_carrier (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .run_en (run_en),
    .cnt_q  (cnt_q),
    .run_q  (run_q),
    .load   (load)
  );

  qpwm_budget #(
    .PERIOD(PERIOD), .DUTY_W(DUTY_W), .DT_W(DT_W),
    .CNT_W(CNT_W), .EW(EW), .MIN_S4(MIN_S4)
  ) u_budget (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .load    (load),
    .duty    (duty_vec),
    .dead_in (dead_cyc),
    .ovl_in  (ovl_cyc),
    .t_q     (t_q),
    .dt_q    (dt_q),
    .ov_q    (ov_q)
  );

  qpwm_decode #(.CNT_W(CNT_W), .DT_W(DT_W), .EW(EW)) u_decode (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .run_en (run_en),
    .run_q  (run_q),
    .cnt_q  (cnt_q),
    .t_q    (t_q),
    .dt_q   (dt_q),
    .ov_q   (ov_q),
    .leg_q  (leg_gate),
    .rect_q (rect_gate),
    .mark_q (cycle_mark)
  );

  // R9
  stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (leg_gate == '0 && rect_gate == '0 && !cycle_mark));

  // R1
  mark_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_mark |=> !cycle_mark);
endmodule

// File: tb/quad_phase_pwm_bench.sv
`timescale 1ns/1ps
module quad_phase_pwm_bench;
  localparam int P    = 200;
  localparam int DW   = 12;
  localparam int TW   = 6;
  localparam int MIN4 = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          run_en = 1'b0;
  logic [DW-1:0] d1 = '0, d2 = '0, d3 = '0;
  logic [TW-1:0] dead = '0, ovl = '0;
  logic [3:0]    leg_gate;
  logic [1:0]    rect_gate;
  logic          cycle_mark;

  always #2.5 clk = ~clk;

  quad_phase_pwm #(.PERIOD(P), .DUTY_W(DW), .DT_W(TW), .MIN_S4(MIN4)) u_quad_phase_pwm (
    .clk(clk), .rst_n(rst_n), .run_en(run_en),
    .duty_leg1(d1), .duty_leg2(d2), .duty_leg3(d3),
    .dead_cyc(dead), .ovl_cyc(ovl),
    .leg_gate(leg_gate), .rect_gate(rect_gate), .cycle_mark(cycle_mark)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [6:0] exp_q[$];
  string      tag_q[$];

  // vector = {mark, rect[1], rect[0], leg[3:0]}
  function automatic logic [6:0] model(input int pd1, input int pd2, input int pd3,
                                       input int pdt, input int pov, input int p);
    int t1, t2, t3, need, avail, a2, b3, b4, s3s, s4s;
    bit g1, g2, g3, g4;
    t1 = pd1 * P / 4096;
    t2 = pd2 * P / 4096;
    t3 = pd3 * P / 4096;
    need = 2 * pdt + MIN4;
    avail = (need >= P) ? 0 : P - need;
    if (t1 > avail) t1 = avail;
    if (t2 > avail - t1) t2 = avail - t1;
    if (t3 > avail - t1 - t2) t3 = avail - t1 - t2;
    a2 = 2 * pdt + t1;
    b3 = a2 + t2;
    b4 = b3 + t3;
    s3s = b3 - pov; if (s3s < a2) s3s = a2;
    s4s = b4 - pov; if (s4s < b3) s4s = b3;
    g1 = (p >= pdt) && (p < pdt + t1);
    g2 = (p >= a2) && (p < b3);
    g3 = (t3 > 0) && (p >= s3s) && (p < b4);
    g4 = (p >= s4s);
    return {(p == 0), !g1, !(g2 || g3), g4, g3, g2, g1};
  endfunction

  task automatic push_period(input int pd1, input int pd2, input int pd3,
                             input int pdt, input int pov, input string tag);
    d1 = pd1[DW-1:0]; d2 = pd2[DW-1:0]; d3 = pd3[DW-1:0];
    dead = pdt[TW-1:0]; ovl = pov[TW-1:0];
    for (int p = 0; p < P; p++) exp_q.push_back(model(pd1, pd2, pd3, pdt, pov, p));
    tag_q.push_back(tag);
  endtask

  task automatic wait_mark();
    @(negedge clk);
    while (!cycle_mark) @(negedge clk);
  endtask

  task automatic check_now(input string tag, input logic [6:0] exp);
    logic [6:0] got;
    got = {cycle_mark, rect_gate, leg_gate};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%b exp=%b", tag, got, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // monitor: one check per observed period
  bit         active = 0;
  int         cyc = 0;
  bit         pmis = 0;
  int         mis_pos = 0;
  logic [6:0] mis_got, mis_exp;
  string      cur_tag;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!active && cycle_mark && exp_q.size() > 0) begin
        active = 1; cyc = 0; pmis = 0; cur_tag = tag_q.pop_front();
      end
      if (active) begin
        logic [6:0] e, g;
        e = exp_q.pop_front();
        g = {cycle_mark, rect_gate, leg_gate};
        if (g !== e && !pmis) begin
          pmis = 1; mis_pos = cyc; mis_got = g; mis_exp = e;
        end
        cyc++;
        if (cyc == P) begin
          checks++;
          if (pmis) begin
            errors++;
            $display("FAIL %s pos %0d got=%b exp=%b", cur_tag, mis_pos, mis_got, mis_exp);
          end
          active = 0;
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_now("R10 outputs low in reset", 7'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_now("R10 R9 idle after reset", 7'b0);

    push_period(1024, 819, 614, 4, 2, "R1 R2 R3 R4 R5 R7 nominal");
    run_en = 1'b1;
    wait_mark(); push_period(2048, 410, 205, 0, 0, "R2 R3 R8 no dead no overlap");
    wait_mark(); push_period(800, 0, 600, 3, 3, "R4 R7 R8 leg2 idle");
    wait_mark(); push_period(1200, 500, 0, 2, 5, "R4 R5 leg3 idle");
    wait_mark(); push_period(3000, 1500, 1000, 5, 2, "R6 leg3 then leg2 trimmed");
    wait_mark(); push_period(4095, 300, 300, 6, 1, "R6 leg1 trimmed");
    wait_mark(); push_period(900, 700, 41, 4, 4, "R4 overlap longer than leg3");
    while (exp_q.size() != 0) @(negedge clk);

    @(negedge clk); run_en = 1'b0;
    @(negedge clk); check_now("R9 gates low after disable", 7'b0);
    d1 = 12'd3000; d2 = 12'd100; dead = 6'd1;
    repeat (5) @(negedge clk);
    check_now("R9 inputs ignored while disabled", 7'b0);

    push_period(1500, 1000, 500, 7, 3, "R9 R1 restart period");
    run_en = 1'b1;
    @(negedge clk); check_now("R9 first cycle after enable", 7'b0);
    @(negedge clk);
    checks++;
    if (cycle_mark !== 1'b1) begin
      errors++;
      $display("FAIL R9 mark after restart got=%b exp=1", cycle_mark);
    end
    push_period(600, 600, 600, 10, 6, "R1 R8 after restart");
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1;
    report();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired got=running exp=finished");
      report();
      $finish;
    end
  end
endmodule